// File: doc/BRIEF.md
# Programmable Top-Priority Interrupt Selector

This block chooses one winner among a set of pending maskable interrupt requests and presents the full 16-bit vector address of that winner to the CPU. Each request line owns a fixed vector whose low byte is 0xF2 for line 0, and each higher line number has a low byte two lower: 0xF2, 0xF0, 0xEE and so on. With the default eight lines, line 7 maps to 0xE4. Line 0 is the external IRQ request. Without software action, the lowest-numbered pending line wins, which is the one with the highest vector address.

Software can move any single line to the top of the order. It does this by writing that line's vector low byte into an 8-bit priority register on a simple register bus. Writes take effect only while the CPU interrupt-mask flag is set. The register can be read back at any time. A stored value that matches no implemented vector is kept as written, but during resolution it is treated as the IRQ value.

The selection logic is combinational from the requests, the mask flag and the stored register. The register is the only state in the block.

Top module: `hpri_resolver`

## Requirements
- R1: After reset, the priority register reads 0xF2, which promotes IRQ (line 0).
- R2: A write to address 0x001F is stored only when `imask` is 1. With `imask` at 0 the write is ignored, and a read afterwards returns the previous value.
- R3: Bit 0 of the priority register always reads 0, whatever value was written.
- R4: A read at address 0x001F returns the register regardless of `imask`. A read at any other address returns 0x00.
- R5: When the promoted line is not pending, the lowest-numbered pending line wins. Its vector low byte is 0xF2 minus twice the line number.
- R6: When the line whose low byte equals the register value is pending, that line wins over every other pending line.
- R7: A register value above 0xF2, or below the lowest implemented low byte (0xE4 for eight lines), is stored and read back as written. During resolution it acts as 0xF2.
- R8: `irq_valid` is 0 when no request is pending or when `imask` is 1. Otherwise `irq_valid` is 1 and `irq_vector` is 0xFF in the upper byte, followed by the winner's low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 8 | Pending request lines; line i has low byte 0xF2-2i |
| imask | input | 1 | CPU interrupt-mask flag (1 = inhibited) |
| addr | input | 16 | Register bus address |
| wr_en | input | 1 | Register bus write strobe |
| wdata | input | 8 | Register bus write data |
| rdata | output | 8 | Register bus read data |
| irq_valid | output | 1 | A maskable winner is being presented |
| irq_vector | output | 16 | Vector address of the winner |

## Verification
The selection outputs and the read data follow their inputs within the same cycle. The bench therefore drives requests, `imask` and the address on a falling edge and samples the outputs two nanoseconds later, before the next rising edge. A register write is captured at the first rising edge after the strobe is raised. Every read-back or resolution check that depends on that write is sampled in the half-cycle after that rising edge, never before it.

// File: rtl/hpri_pkg.sv
package hpri_pkg;

    // Vector low byte owned by request line idx: top_low minus two per line.
    function automatic logic [7:0] line_low(input int idx, input logic [7:0] top_low);
        return top_low - 8'(2 * idx);
    endfunction

endpackage

// File: rtl/hpri_sel_reg.sv
module hpri_sel_reg #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h001F,
    parameter logic [7:0]  RST_VAL  = 8'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              imask,
    output logic [7:0]        q,
    output logic [7:0]        rdata
);
    localparam logic [7:0] RST_CLEAN = {RST_VAL[7:1], 1'b0};

    logic hit;
    logic wr_ok;

    assign hit   = (addr == REG_ADDR);
    assign wr_ok = wr_en && hit && imask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_CLEAN;
        end else if (wr_ok) begin
            q <= {wdata[7:1], 1'b0};
        end
    end

    always_comb begin
        rdata = hit ? q : 8'h00;
    end

    // R2: a write while interrupts are enabled leaves the register untouched
    assert_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !imask) |=> $stable(q));

    // R3: bit 0 of the stored value is never set
    assert_bit0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q[0] == 1'b0);

    // R2: an accepted write lands in the register
    assert_wr_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && imask) |=> (q == {$past(wdata[7:1]), 1'b0}));

endmodule

// File: rtl/hpri_pick.sv
module hpri_pick #(
    parameter int unsigned SRC_N   = 8,
    parameter logic [7:0]  TOP_LOW = 8'hF2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] req,
    input  logic             imask,
    input  logic [7:0]       prio,
    output logic             valid,
    output logic [7:0]       win_low
);
    import hpri_pkg::*;

    localparam int unsigned IW = (SRC_N > 1) ? $clog2(SRC_N) : 1;

    logic [SRC_N-1:0] match;
    logic [IW-1:0]    prom_idx;
    logic [IW-1:0]    win_idx;
    logic             any_req;

    // One comparator per line against the stored priority byte.
    for (genvar g = 0; g < SRC_N; g++) begin : g_match
        assign match[g] = (prio == line_low(g, TOP_LOW));
    end

    // Promoted line: the matching one, or line 0 (IRQ) if none matches.
    always_comb begin
        prom_idx = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (match[i]) prom_idx = IW'(i);
        end
    end

    // Winner: promoted line if pending, else the lowest-numbered pending line.
    always_comb begin
        win_idx = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IW'(i);
        end
        if (req[prom_idx]) win_idx = prom_idx;
    end

    assign any_req = |req;
    assign valid   = any_req && !imask;
    assign win_low = line_low(int'(win_idx), TOP_LOW);

    // R5: a presented winner is always a pending line
    assert_winner_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[win_idx]);

    // R6: a pending promoted line is never overtaken
    assert_prom_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (|match) && (req & match) != '0) |-> (win_low == prio));

    // R8: masked or idle means no valid output
    assert_masked_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (imask || req == '0) |-> !valid);

    // R6: at most one line claims the stored byte
    assert_match_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/hpri_resolver.sv
module hpri_resolver #(
    parameter int unsigned SRC_N    = 8,
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h001F,
    parameter logic [7:0]  TOP_LOW  = 8'hF2,
    parameter logic [7:0]  VEC_HI   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  req,
    input  logic              imask,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq_valid,
    output logic [15:0]       irq_vector
);
    logic [7:0] prio_q;
    logic [7:0] win_low;

    hpri_sel_reg #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR),
        .RST_VAL (TOP_LOW)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wr_en(wr_en),
        .wdata(wdata),
        .imask(imask),
        .q    (prio_q),
        .rdata(rdata)
    );

    hpri_pick #(
        .SRC_N  (SRC_N),
        .TOP_LOW(TOP_LOW)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .imask  (imask),
        .prio   (prio_q),
        .valid  (irq_valid),
        .win_low(win_low)
    );

    assign irq_vector = {VEC_HI, win_low};

    // R8: upper vector byte is constant whenever a winner is shown
    assert_vec_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector[15:8] == VEC_HI));

endmodule

// File: tb/hpri_resolver_bench.sv
`timescale 1ns/1ps
module hpri_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic        imask = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_valid;
    logic [15:0] irq_vector;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hpri_resolver u_hpri_resolver (
        .clk(clk), .rst_n(rst_n), .req(req), .imask(imask), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    // Row: {prio[7:0], req[7:0], imask, exp_valid, exp_low[7:0]}
    localparam int NV = 9;
    localparam logic [25:0] TBL [NV] = '{
        {8'hF2, 8'b0000_0110, 1'b0, 1'b1, 8'hF0}, // R5 line1 beats line2
        {8'hF2, 8'b1000_0000, 1'b0, 1'b1, 8'hE4}, // R5 only line7
        {8'hE8, 8'b0010_0011, 1'b0, 1'b1, 8'hE8}, // R6 line5 promoted
        {8'hE8, 8'b0000_0011, 1'b0, 1'b1, 8'hF2}, // R5 promoted idle
        {8'hF0, 8'b0000_0011, 1'b0, 1'b1, 8'hF0}, // R6 line1 over IRQ
        {8'hF4, 8'b0000_0110, 1'b0, 1'b1, 8'hF0}, // R7 high invalid
        {8'hE2, 8'b0000_0101, 1'b0, 1'b1, 8'hF2}, // R7 low invalid
        {8'hF0, 8'b0000_0010, 1'b1, 1'b0, 8'h00}, // R8 masked
        {8'hEC, 8'b0000_0000, 1'b0, 1'b0, 8'h00}  // R8 idle
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write on the bus; the value lands at the next rising edge.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic m);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; imask = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic m, output logic [7:0] d);
        @(negedge clk);
        addr = a; imask = m;
        #2;
        d = rdata;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value
        bus_read(16'h001F, 1'b0, rd);
        check("R1 reset value", {8'h00, rd}, 16'h00F2);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [25:0] row;
            row = TBL[i];
            bus_write(16'h001F, row[25:18], 1'b1);
            @(negedge clk);
            req = row[17:10];
            imask = row[9];
            addr = 16'h0000;
            #2;
            check($sformatf("R5/R6/R7/R8 row %0d valid", i), {15'h0, irq_valid}, {15'h0, row[8]});
            if (row[8])
                check($sformatf("R5/R6/R7/R8 row %0d vector", i), irq_vector, {8'hFF, row[7:0]});
        end
        req = '0;

        // R2 write ignored while interrupts enabled
        bus_write(16'h001F, 8'hEE, 1'b1);
        bus_write(16'h001F, 8'hE6, 1'b0);
        bus_read(16'h001F, 1'b1, rd);
        check("R2 write ignored", {8'h00, rd}, 16'h00EE);
        @(negedge clk);
        req = 8'b0100_0001; imask = 1'b0;
        #2;
        check("R2 ignored write no effect on resolution", irq_vector, 16'hFFF2);
        req = '0;

        // R3 bit 0 reads zero
        bus_write(16'h001F, 8'hF1, 1'b1);
        bus_read(16'h001F, 1'b1, rd);
        check("R3 bit0 cleared", {8'h00, rd}, 16'h00F0);

        // R4 readable with imask clear, other address reads zero
        bus_read(16'h001F, 1'b0, rd);
        check("R4 read with imask 0", {8'h00, rd}, 16'h00F0);
        bus_read(16'h001E, 1'b1, rd);
        check("R4 other address", {8'h00, rd}, 16'h0000);

        // R4 write to other address does not touch register
        bus_write(16'h0020, 8'hE4, 1'b1);
        bus_read(16'h001F, 1'b1, rd);
        check("R4 foreign write", {8'h00, rd}, 16'h00F0);

        // R7 invalid value stored as written
        bus_write(16'h001F, 8'hFA, 1'b1);
        bus_read(16'h001F, 1'b1, rd);
        check("R7 invalid readback", {8'h00, rd}, 16'h00FA);
        @(negedge clk);
        req = 8'b0000_0011; imask = 1'b0;
        #2;
        check("R7 invalid acts as IRQ", irq_vector, 16'hFFF2);
        req = '0;

        // R6 lowest line promoted over all others
        bus_write(16'h001F, 8'hE4, 1'b1);
        @(negedge clk);
        req = 8'hFF; imask = 1'b0;
        #2;
        check("R6 line7 promoted", irq_vector, 16'hFFE4);

        // R1 reset again restores IRQ value
        @(negedge clk);
        req = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(16'h001F, 1'b0, rd);
        check("R1 value after second reset", {8'h00, rd}, 16'h00F2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule